// File: doc/BRIEF.md
# Operand-Capturing Reservation Station

This block is a single-entry reservation station that sits in front of one execution unit in an out-of-order core that resolves register dependencies by tag. Decode hands it an opcode, two operand words read from the register file and, for each operand, a producer tag plus two hazard flags. A set flag means the operand is still being computed by an earlier instruction. Each flag names which word of the write-back bus will carry the value: the first flag names the first result word, the second flag names the second word. The second word exists for the other half of a double-width floating-point result.

The station has two slots. The waiting slot holds an entry while any hazard is outstanding. It watches the write-back bus and captures forwarded words as they are broadcast. When the write-back tag matches an operand's stored producer tag, that operand's hazards are cleared. Once nothing is outstanding and the ready slot is empty, or is being emptied in the same cycle, the entry moves to the ready slot. The execution unit accepts the ready entry with a one-cycle take strobe. An instruction that arrives with no hazards while the ready slot is free goes straight to the ready slot. A free indication tells decode when it may issue again.

Top module: `opnd_rsv_station`

## Requirements
- R1: After synchronous reset, the station is empty: `slot_free` is 1, `ex_valid` is 0, and `ex_op`, `ex_a` and `ex_b` are 0.
- R2: An issue (`issue_en` high at a clock edge) whose operands carry any hazard flag leaves the entry in the waiting slot. From the next cycle, `slot_free` is 0 and `ex_valid` stays 0.
- R3: Hazard flag bit 0 of an operand selects `wb_res_hi` as the forwarding source and bit 1 selects `wb_res_lo`. When both bits are set, bit 0 wins.
- R4: A write-back with `wb_valid` high and `wb_tag` equal to an operand's stored nonzero producer tag clears both hazard flags of that operand. The value that operand delivers to execution is the selected bus word from that same cycle.
- R5: A write-back with `wb_tag` equal to 0 never clears a hazard, even with `wb_valid` high.
- R6: A write-back whose tag differs from an operand's producer tag leaves that operand's hazards set, and the entry keeps waiting.
- R7: An entry moves at the clock edge where its last hazard clears, provided the ready slot is empty or being taken. From the next cycle, `ex_valid` is 1 with the opcode and final operands, and `slot_free` is 1.
- R8: An issue with no hazard flags, made while the ready slot is free, appears on the ready outputs in the cycle after the issue edge, and `slot_free` stays 1.
- R9: The ready outputs hold steady until `take_op`. A take with nothing arriving drives `ex_valid`, `ex_op`, `ex_a` and `ex_b` to 0 from the next cycle. A take while the ready slot is empty has no effect.
- R10: A ready entry waits in the waiting slot while the ready slot is occupied and not taken. It moves at the same edge as the take that empties the ready slot.
- R11: A write-back in the issue cycle that matches the issuing operand's producer tag clears that hazard at once and supplies the operand's value.
- R12: Issue is allowed only while `slot_free` is 1. Issuing into an occupied waiting slot is a protocol violation.
- R13: A synchronous `flush` empties both slots and drops all hazards. It takes priority over a simultaneous issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of both slots |
| issue_en | input | 1 | Issue strobe from decode |
| issue_op | input | 6 | Decoded opcode |
| issue_a | input | 32 | Operand A value from register file |
| issue_b | input | 32 | Operand B value from register file |
| issue_tag_a | input | 3 | Producer tag for operand A |
| issue_tag_b | input | 3 | Producer tag for operand B |
| issue_haz_a | input | 2 | Hazard flags for A (bit 0 = first word, bit 1 = second word) |
| issue_haz_b | input | 2 | Hazard flags for B (same encoding) |
| wb_valid | input | 1 | Write-back bus valid |
| wb_tag | input | 3 | Tag of the producing instruction (0 = none) |
| wb_res_hi | input | 32 | First write-back result word |
| wb_res_lo | input | 32 | Second write-back result word |
| take_op | input | 1 | Execution unit accepts the ready entry |
| slot_free | output | 1 | Waiting slot is empty, decode may issue |
| ex_valid | output | 1 | Ready slot holds an instruction |
| ex_op | output | 6 | Ready opcode |
| ex_a | output | 32 | Ready operand A |
| ex_b | output | 32 | Ready operand B |

## Verification
Every cycle, the assertions check the following:
- decode never issues into an occupied waiting slot;
- a hazard flag never drops without a write-back carrying its producer tag;
- the ready outputs hold steady until taken;
- a take or a flush empties the slots.

Only the bench scenarios can show that the right bus word lands in each operand and that the move happens in the intended cycle. The bench sweeps every hazard-flag combination on both operands, with shared and distinct producer tags. The other cases it covers are a zero tag, an issue-cycle match, the move that waits for a take, and flush.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    parameter int DATA_W = 32;
    parameter int TAG_W  = 3;
    parameter int OP_W   = 6;
    parameter int N_OPND = 2;
    parameter int N_HALF = 2;

    localparam logic [TAG_W-1:0] NO_TAG = '0;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [N_HALF-1:0] haz_t;
    typedef logic [OP_W-1:0]   op_t;

    // one operand as held in the waiting slot
    typedef struct packed {
        word_t val;
        tag_t  tag;
        haz_t  haz;
    } opnd_t;

    // write-back broadcast; word[0] is the first result word
    typedef struct packed {
        logic                   vld;
        tag_t                   tag;
        word_t [N_HALF-1:0]     word;
    } wb_t;

    function automatic logic tag_hit(wb_t wb, tag_t t);
        return wb.vld && (wb.tag != NO_TAG) && (wb.tag == t);
    endfunction

    // lowest flagged half wins
    function automatic word_t pick_word(haz_t h, wb_t wb, word_t keep);
        word_t r;
        r = keep;
        for (int i = N_HALF - 1; i >= 0; i--) begin
            if (h[i]) r = wb.word[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/rsv_opnd_track.sv
module rsv_opnd_track
    import rsv_pkg::*;
(
    input  opnd_t src,
    input  wb_t   wb,
    output opnd_t nxt
);

    logic hit;

    always_comb begin
        hit     = tag_hit(wb, src.tag);
        nxt.val = pick_word(src.haz, wb, src.val);
        nxt.tag = src.tag;
        nxt.haz = hit ? '0 : src.haz;
    end

endmodule

// File: rtl/rsv_busy_slot.sv
module rsv_busy_slot
    import rsv_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     issue_en,
    input  op_t                      issue_op,
    input  opnd_t [N_OPND-1:0]       issue_opnd,
    input  wb_t                      wb,
    input  logic                     exec_free,
    output logic                     occupied,
    output logic                     move,
    output op_t                      move_op,
    output word_t [N_OPND-1:0]       move_val
);

    logic               vld_q;
    op_t                op_q;
    opnd_t [N_OPND-1:0] opnd_q;
    opnd_t [N_OPND-1:0] src;
    opnd_t [N_OPND-1:0] nxt;
    logic               src_vld;
    op_t                src_op;
    logic               all_clear;
    logic               keep;

    assign src_vld = issue_en | vld_q;
    assign src_op  = issue_en ? issue_op : op_q;

    genvar gi;
    generate
        for (gi = 0; gi < N_OPND; gi++) begin : g_opnd
            assign src[gi] = issue_en ? issue_opnd[gi] : opnd_q[gi];

            rsv_opnd_track u_trk (
                .src (src[gi]),
                .wb  (wb),
                .nxt (nxt[gi])
            );

            assign move_val[gi] = nxt[gi].val;

            // R6
            haz_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (vld_q && !issue_en && !flush && (opnd_q[gi].haz != '0)
                 && !(wb.vld && (wb.tag == opnd_q[gi].tag)))
                |=> (vld_q && $stable(opnd_q[gi].haz)));
        end
    endgenerate

    always_comb begin
        all_clear = 1'b1;
        for (int i = 0; i < N_OPND; i++) begin
            if (nxt[i].haz != '0) all_clear = 1'b0;
        end
    end

    assign move     = src_vld && all_clear && exec_free && !flush;
    assign move_op  = src_op;
    assign keep     = src_vld && !move;
    assign occupied = vld_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            vld_q  <= 1'b0;
            op_q   <= '0;
            opnd_q <= '0;
        end else begin
            vld_q  <= keep;
            op_q   <= keep ? src_op : '0;
            opnd_q <= keep ? nxt : '0;
        end
    end

    // R12
    issue_gate_chk: assert property (@(posedge clk) disable iff (rst)
        issue_en |-> !vld_q);

endmodule

// File: rtl/rsv_exec_slot.sv
module rsv_exec_slot
    import rsv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 load,
    input  op_t                  load_op,
    input  word_t [N_OPND-1:0]   load_val,
    input  logic                 take,
    output logic                 free,
    output logic                 vld,
    output op_t                  op,
    output word_t [N_OPND-1:0]   val
);

    assign free = !vld || take;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            vld <= 1'b0;
            op  <= '0;
            val <= '0;
        end else if (load) begin
            vld <= 1'b1;
            op  <= load_op;
            val <= load_val;
        end else if (take) begin
            vld <= 1'b0;
            op  <= '0;
            val <= '0;
        end
    end

    // R9
    exec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && !take && !flush) |=> (vld && $stable(op) && $stable(val)));

    // R9
    exec_take_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && take && !load && !flush) |=> (!vld && (val == '0)));

    // R13
    exec_flush_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !vld);

endmodule

// File: rtl/opnd_rsv_station.sv
module opnd_rsv_station
    import rsv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              issue_en,
    input  logic [OP_W-1:0]   issue_op,
    input  logic [DATA_W-1:0] issue_a,
    input  logic [DATA_W-1:0] issue_b,
    input  logic [TAG_W-1:0]  issue_tag_a,
    input  logic [TAG_W-1:0]  issue_tag_b,
    input  logic [N_HALF-1:0] issue_haz_a,
    input  logic [N_HALF-1:0] issue_haz_b,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_res_hi,
    input  logic [DATA_W-1:0] wb_res_lo,
    input  logic              take_op,
    output logic              slot_free,
    output logic              ex_valid,
    output logic [OP_W-1:0]   ex_op,
    output logic [DATA_W-1:0] ex_a,
    output logic [DATA_W-1:0] ex_b
);

    wb_t                wb;
    opnd_t [N_OPND-1:0] issue_opnd;
    word_t [N_OPND-1:0] move_val;
    word_t [N_OPND-1:0] ex_val;
    op_t                move_op;
    logic               move;
    logic               occupied;
    logic               exec_free;

    assign wb.vld     = wb_valid;
    assign wb.tag     = wb_tag;
    assign wb.word[0] = wb_res_hi;
    assign wb.word[1] = wb_res_lo;

    assign issue_opnd[0] = '{val: issue_a, tag: issue_tag_a, haz: issue_haz_a};
    assign issue_opnd[1] = '{val: issue_b, tag: issue_tag_b, haz: issue_haz_b};

    rsv_busy_slot u_busy (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .issue_en   (issue_en),
        .issue_op   (issue_op),
        .issue_opnd (issue_opnd),
        .wb         (wb),
        .exec_free  (exec_free),
        .occupied   (occupied),
        .move       (move),
        .move_op    (move_op),
        .move_val   (move_val)
    );

    rsv_exec_slot u_exec (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .load     (move),
        .load_op  (move_op),
        .load_val (move_val),
        .take     (take_op),
        .free     (exec_free),
        .vld      (ex_valid),
        .op       (ex_op),
        .val      (ex_val)
    );

    assign slot_free = !occupied;
    assign ex_a      = ex_val[0];
    assign ex_b      = ex_val[1];

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        rst |=> (slot_free && !ex_valid));

    // R13
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (slot_free && !ex_valid));

endmodule

// File: tb/opnd_rsv_station_test.sv
module opnd_rsv_station_test;

    logic        clk = 1'b0;
    logic        rst, flush, issue_en, wb_valid, take_op;
    logic [5:0]  issue_op;
    logic [31:0] issue_a, issue_b, wb_res_hi, wb_res_lo;
    logic [2:0]  issue_tag_a, issue_tag_b, wb_tag;
    logic [1:0]  issue_haz_a, issue_haz_b;
    logic        slot_free, ex_valid;
    logic [5:0]  ex_op;
    logic [31:0] ex_a, ex_b;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    opnd_rsv_station uut (
        .clk(clk), .rst(rst), .flush(flush), .issue_en(issue_en),
        .issue_op(issue_op), .issue_a(issue_a), .issue_b(issue_b),
        .issue_tag_a(issue_tag_a), .issue_tag_b(issue_tag_b),
        .issue_haz_a(issue_haz_a), .issue_haz_b(issue_haz_b),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_res_hi(wb_res_hi),
        .wb_res_lo(wb_res_lo), .take_op(take_op), .slot_free(slot_free),
        .ex_valid(ex_valid), .ex_op(ex_op), .ex_a(ex_a), .ex_b(ex_b)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    // one clock edge, then restore idle inputs with fresh junk on the bus
    task automatic tick();
        @(posedge clk);
        #2;
        cyc++;
        issue_en  = 1'b0;
        wb_valid  = 1'b0;
        wb_tag    = 3'd0;
        take_op   = 1'b0;
        flush     = 1'b0;
        wb_res_hi = 32'hDEAD_0000 | 32'(cyc);
        wb_res_lo = 32'hBEEF_0000 | 32'(cyc);
    endtask

    task automatic set_issue(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                             input logic [2:0] ta, input logic [2:0] tb,
                             input logic [1:0] ha, input logic [1:0] hb);
        issue_en = 1'b1; issue_op = op; issue_a = a; issue_b = b;
        issue_tag_a = ta; issue_tag_b = tb; issue_haz_a = ha; issue_haz_b = hb;
    endtask

    task automatic set_wb(input logic [2:0] t, input logic [31:0] hi, input logic [31:0] lo);
        wb_valid = 1'b1; wb_tag = t; wb_res_hi = hi; wb_res_lo = lo;
    endtask

    task automatic expect_wait(input string req);
        chk_eq({req, " slot_free"}, 32'(slot_free), 32'd0);
        chk_eq({req, " ex_valid"}, 32'(ex_valid), 32'd0);
    endtask

    task automatic expect_exec(input string req, input logic [5:0] op,
                               input logic [31:0] a, input logic [31:0] b, input bit free);
        chk_eq({req, " ex_valid"}, 32'(ex_valid), 32'd1);
        chk_eq({req, " ex_op"}, 32'(ex_op), 32'(op));
        chk_eq({req, " ex_a"}, ex_a, a);
        chk_eq({req, " ex_b"}, ex_b, b);
        chk_eq({req, " slot_free"}, 32'(slot_free), 32'(free));
    endtask

    task automatic expect_empty(input string req);
        chk_eq({req, " ex_valid"}, 32'(ex_valid), 32'd0);
        chk_eq({req, " ex_op"}, 32'(ex_op), 32'd0);
        chk_eq({req, " ex_a"}, ex_a, 32'd0);
        chk_eq({req, " ex_b"}, ex_b, 32'd0);
        chk_eq({req, " slot_free"}, 32'(slot_free), 32'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        rst = 1'b1; flush = 1'b0; issue_en = 1'b0; wb_valid = 1'b0; take_op = 1'b0;
        issue_op = '0; issue_a = '0; issue_b = '0; issue_tag_a = '0; issue_tag_b = '0;
        issue_haz_a = '0; issue_haz_b = '0; wb_tag = '0; wb_res_hi = '0; wb_res_lo = '0;
        tick(); rst = 1'b1; tick(); rst = 1'b1; tick();
        rst = 1'b0;
        expect_empty("R1 reset");

        // sweep of hazard flag combinations, shared and distinct producer tags
        for (int n = 0; n < 32; n++) begin
            int hza = n % 4;
            int hzb = (n / 4) % 4;
            bit same = n[4];
            logic [2:0] ta = 3'(1 + n % 7);
            logic [2:0] tb = same ? ta : 3'(1 + (n + 3) % 7);
            logic [31:0] va = 32'h0A00_0000 + 32'(n * 33);
            logic [31:0] vb = 32'h0B00_0000 + 32'(n * 57);
            logic [31:0] ea = va;
            logic [31:0] eb = vb;
            logic [5:0]  op = 6'(n + 1);
            logic [31:0] hi, lo;
            bit pa = (hza != 0);
            bit pb = (hzb != 0);

            chk_eq("R12 free before issue", 32'(slot_free), 32'd1);
            set_issue(op, va, vb, ta, tb, 2'(hza), 2'(hzb));
            tick();
            if (!pa && !pb) begin
                expect_exec("R8 direct pass", op, ea, eb, 1'b1);
            end else begin
                expect_wait("R2 waiting after issue");
                set_wb(3'd0, 32'h5555_0000 + 32'(n), 32'h6666_0000 + 32'(n));
                tick();
                expect_wait("R5 zero tag");
                hi = 32'h1100_0000 + 32'(n);
                lo = 32'h2200_0000 + 32'(n);
                set_wb(ta, hi, lo);
                tick();
                if (pa) ea = (hza % 2 == 1) ? hi : lo;   // R3 bit0 -> hi priority
                if (pb && same) begin
                    eb = (hzb % 2 == 1) ? hi : lo;
                    pb = 1'b0;
                end
                if (pb) begin
                    expect_wait("R6 other tag");
                    hi = 32'h3300_0000 + 32'(n);
                    lo = 32'h4400_0000 + 32'(n);
                    set_wb(tb, hi, lo);
                    tick();
                    eb = (hzb % 2 == 1) ? hi : lo;
                end
                expect_exec("R4 R7 forwarded move", op, ea, eb, 1'b1);
            end
            repeat (2) tick();
            expect_exec("R9 hold", op, ea, eb, 1'b1);
            take_op = 1'b1;
            tick();
            expect_empty("R9 take clears");
        end

        // R9 take while empty is ignored, waiting entry unaffected
        set_issue(6'd7, 32'h7, 32'h8, 3'd2, 3'd3, 2'b01, 2'b00);
        tick();
        take_op = 1'b1;
        tick();
        expect_wait("R9 empty take");
        set_wb(3'd2, 32'hABCD_0001, 32'h0);
        tick();
        expect_exec("R9 after empty take", 6'd7, 32'hABCD_0001, 32'h8, 1'b1);

        // R10 ready entry waits behind an untaken exec entry
        set_issue(6'd9, 32'h90, 32'h91, 3'd1, 3'd1, 2'b00, 2'b00);
        tick();
        expect_exec("R10 first held", 6'd7, 32'hABCD_0001, 32'h8, 1'b0);
        tick();
        expect_exec("R10 still held", 6'd7, 32'hABCD_0001, 32'h8, 1'b0);
        take_op = 1'b1;
        tick();
        expect_exec("R10 moves on take", 6'd9, 32'h90, 32'h91, 1'b1);
        take_op = 1'b1;
        tick();
        expect_empty("R10 drained");

        // R11 issue-cycle match
        set_issue(6'd11, 32'h1, 32'h2, 3'd5, 3'd6, 2'b10, 2'b00);
        set_wb(3'd5, 32'h0, 32'hC0DE_0011);
        tick();
        expect_exec("R11 same-cycle match", 6'd11, 32'hC0DE_0011, 32'h2, 1'b1);

        // R13 flush with both slots occupied
        set_issue(6'd12, 32'h3, 32'h4, 3'd4, 3'd4, 2'b01, 2'b10);
        tick();
        flush = 1'b1;
        tick();
        expect_empty("R13 flush both");

        // R13 flush beats simultaneous issue
        set_issue(6'd13, 32'h5, 32'h6, 3'd1, 3'd1, 2'b00, 2'b00);
        flush = 1'b1;
        tick();
        expect_empty("R13 flush over issue");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule